// File: doc/BRIEF.md
# Serial Register-Bank Slave with Deferred Readback

This block lets an external serial host read and write a bank of 2^ADDR_W registers, each DATA_W bits wide (64 x 16 by default). The host lowers an active-low select, clocks a fixed 24-bit command word in on SDI, most significant bit first, and raises the select again. The command word has four fields, from the top bit down: a direction flag (0 = write, 1 = read), a spare bit, the 6-bit register index and the 16-bit data word. The spare bit is ignored but echoed. A write takes effect when the select returns high, and only if at least 24 bits arrived.

A read is answered one frame late. When a read frame closes, the addressed register is captured. During the next frame the block shifts out 24 bits on SDO. These are the previous frame's direction flag, spare bit and index, followed by the captured word. After a frame that was not a read, the same header echo goes out with a data field of zero. Register 2 holds the serial configuration. Bit 0 enables the SDO driver. Bit 1 picks the SDO launch edge: 1 means falling, 0 means rising. Both bits reset to 0. The SDO pad is modelled as a data pin plus an output-enable pin.

All serial pins are brought into the system clock domain through synchronizers and handled as sampled edges. This requires SCLK to be slow compared to the system clock. The chip side reads any register through a plain combinational port. That port has no flow control, because it only reads the bank.

Top module: `spi_regbank`

## Requirements
- R1: After reset every register reads 0, `sdo_oe` is low, and the response loaded into the first frame is all zeros.
- R2: SDI is sampled on each falling SCLK edge while `cs_n` is low, most significant bit first. A frame with bit 23 = 0 writes bits 15..0 into the register indexed by bits 21..16, and the write takes effect after `cs_n` rises.
- R3: A frame with fewer than 24 falling SCLK edges has no effect. No register changes, and the response for the next frame is the same as before the short frame.
- R4: Bits after the 24th falling edge of a frame are ignored. The write and the response use only the first 24 bits.
- R5: While `cs_n` is high, activity on SCLK and SDI changes no register and no pending response, and `sdo_oe` is low.
- R6: `sdo_oe` is high only while `cs_n` is low and bit 0 of register 2 is 1.
- R7: After an accepted frame with bit 23 = 1, the next frame's SDO stream is the previous bits 23..16 followed by the contents the indexed register held when that read frame closed.
- R8: After an accepted frame with bit 23 = 0, the next frame's SDO stream is the previous bits 23..16 followed by sixteen zero bits.
- R9: With register 2 bit 1 = 1, SDO shows bit 23 from the start of the frame and moves to the next bit on each falling SCLK edge. With bit 1 = 0, SDO shows bit 23 until the second rising edge, and rising edge k (k >= 2) presents bit 24-k.
- R10: `core_rdata` always shows the current contents of the register indexed by `core_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (meaningful when `sdo_oe` is high) |
| sdo_oe | output | 1 | SDO driver enable; the pad is high-impedance when low |
| core_addr | input | ADDR_W | Chip-side register index |
| core_rdata | output | DATA_W | Contents of the register at `core_addr` |

## Verification
The assertions assume that every level on `cs_n`, `sclk` and `sdi` lasts several system clocks. In particular, each SCLK phase must outlast the synchronizer. The assertions also assume that SDI is stable across a falling SCLK edge and that `cs_n` stays high for a few clocks between frames. The stimulus keeps within these limits by changing SDI only while SCLK is high, holding each SCLK phase for eight clocks and leaving an eight-clock gap after each frame. Random frames vary the direction flag, the index, the data and the frame length (short, exact and overlong). Random writes to register 2 also switch the SDO enable and the launch edge during the run.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  // Fixed bit positions inside the configuration register
  localparam int CFG_OE_BIT   = 0;
  localparam int CFG_EDGE_BIT = 1;

  typedef enum logic {
    LAUNCH_RISE = 1'b0,
    LAUNCH_FALL = 1'b1
  } launch_edge_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic active,
  output logic frame_start,
  output logic frame_end,
  output logic sclk_fall,
  output logic sclk_rise,
  output logic sdi_s
);
  logic [STAGES-1:0] cs_q, ck_q, di_q;
  logic cs_prev, ck_prev;
  logic cs_s, ck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '1;
      ck_q    <= '0;
      di_q    <= '0;
      cs_prev <= 1'b1;
      ck_prev <= 1'b0;
    end else begin
      cs_q    <= {cs_q[STAGES-2:0], cs_n};
      ck_q    <= {ck_q[STAGES-2:0], sclk};
      di_q    <= {di_q[STAGES-2:0], sdi};
      cs_prev <= cs_s;
      ck_prev <= ck_s;
    end
  end

  assign cs_s        = cs_q[STAGES-1];
  assign ck_s        = ck_q[STAGES-1];
  assign sdi_s       = di_q[STAGES-1];
  assign active      = ~cs_s;
  assign frame_start = cs_prev & ~cs_s;
  assign frame_end   = ~cs_prev & cs_s;
  assign sclk_fall   = active & ck_prev & ~ck_s;
  assign sclk_rise   = active & ~ck_prev & ck_s;

  // R5: no clock edge is reported outside a frame
  a_r5_edges_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(sclk_fall || sclk_rise));
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  output logic              accept,
  output logic              f_rd,
  output logic              f_spare,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_data
);
  localparam int FRAME_BITS = 2 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic                  full;

  assign full = (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (frame_start) begin
      cnt <= '0;
    end else if (sclk_fall && !full) begin
      shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
      cnt   <= cnt + 1'b1;
    end
  end

  assign accept  = frame_end & full;
  assign f_rd    = shreg[FRAME_BITS-1];
  assign f_spare = shreg[FRAME_BITS-2];
  assign f_addr  = shreg[DATA_W +: ADDR_W];
  assign f_data  = shreg[DATA_W-1:0];

  a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r4_full_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    full && !frame_start |=> $stable(shreg));
  a_r5_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(shreg));
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int CFG_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  input  logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_rdata,
  output logic              cfg_oe,
  output logic              cfg_fall
);
  import spi_rb_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign cap_data   = mem[cap_addr];
  assign core_rdata = mem[core_addr];
  assign cfg_oe     = mem[CFG_ADDR][CFG_OE_BIT];
  assign cfg_fall   = mem[CFG_ADDR][CFG_EDGE_BIT];

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
  a_r3_no_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(core_addr) || $stable(core_rdata)));
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              f_rd,
  input  logic              f_spare,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              frame_start,
  input  logic              sclk_fall,
  input  logic              sclk_rise,
  input  logic              launch_fall,
  output logic              sdo_bit
);
  import spi_rb_pkg::*;
  localparam int FRAME_BITS = 2 + ADDR_W + DATA_W;

  logic [FRAME_BITS-1:0] pending;
  logic [FRAME_BITS-1:0] shreg;
  logic                  armed;
  logic                  launch;
  launch_edge_e          edge_sel;

  assign edge_sel = launch_edge_e'(launch_fall);
  assign launch   = (edge_sel == LAUNCH_FALL) ? sclk_fall : sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (accept) begin
      pending <= {f_rd, f_spare, f_addr, (f_rd ? cap_data : {DATA_W{1'b0}})};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      armed <= 1'b0;
    end else if (frame_start) begin
      shreg <= pending;
      armed <= 1'b0;
    end else if (launch) begin
      if (edge_sel == LAUNCH_FALL || armed)
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
      armed <= 1'b1;
    end
  end

  assign sdo_bit = shreg[FRAME_BITS-1];

  a_r3_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(pending));
  a_r9_first_rise_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_fall && sclk_rise && !armed && !frame_start |=> $stable(shreg));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int CFG_ADDR    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_rdata
);
  logic active, frame_start, frame_end, sclk_fall, sclk_rise, sdi_s;
  logic accept, f_rd, f_spare;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data, cap_data;
  logic cfg_oe, cfg_fall;
  logic oe_q;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .active(active), .frame_start(frame_start), .frame_end(frame_end),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .sdi_s(sdi_s));

  spi_rb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .frame_start(frame_start),
    .frame_end(frame_end), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .accept(accept), .f_rd(f_rd), .f_spare(f_spare), .f_addr(f_addr),
    .f_data(f_data));

  spi_rb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(accept & ~f_rd), .wr_addr(f_addr),
    .wr_data(f_data), .cap_addr(f_addr), .cap_data(cap_data),
    .core_addr(core_addr), .core_rdata(core_rdata),
    .cfg_oe(cfg_oe), .cfg_fall(cfg_fall));

  spi_rb_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .accept(accept), .f_rd(f_rd), .f_spare(f_spare),
    .f_addr(f_addr), .cap_data(cap_data), .frame_start(frame_start),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .launch_fall(cfg_fall),
    .sdo_bit(sdo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= active & cfg_oe;
  end
  assign sdo_oe = oe_q;

  a_r6_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sdo_oe);
  a_r6_oe_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_oe |=> !sdo_oe);
endmodule

// File: tb/spi_regbank_test.sv
module spi_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int H   = 8;
  localparam int GAP = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [5:0]  core_addr = '0;
  logic [15:0] core_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] mem_m [64];
  logic [23:0] pend_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regbank uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .core_addr(core_addr), .core_rdata(core_rdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [23:0] next_pend(input bit rw, input bit sp, input logic [5:0] a);
    return {rw, sp, a, (rw ? mem_m[a] : 16'h0000)};
  endfunction

  task automatic core_chk(input logic [5:0] a, input string tag);
    core_addr = a;
    @(negedge clk);
    chk(core_rdata === mem_m[a], tag, {16'h0, core_rdata}, {16'h0, mem_m[a]});
  endtask

  task automatic xfer(input bit rw, input bit sp, input logic [5:0] a, input logic [15:0] d, input int n);
    logic [23:0] w, ex, got;
    bit oe, fall, oe_bad, exp_b;
    int bad;
    w = {rw, sp, a, d};
    ex = pend_m;
    oe = mem_m[2][0];
    fall = mem_m[2][1];
    got = '0; bad = 0; oe_bad = 0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'($urandom);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (i < 24) begin
        if (sdo_oe !== oe) oe_bad = 1;
        if (oe) begin
          got[23-i] = sdo;
          if (sdo !== ex[23-i]) bad++;
        end
      end
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      if (oe && i < 23) begin
        exp_b = fall ? ex[22-i] : ex[23-i];
        if (sdo !== exp_b) bad++;
      end
    end
    cs_n = 1'b1;
    sdi = 1'b0;
    repeat (GAP) @(negedge clk);
    chk(!oe_bad, "R6 sdo_oe during frame", {31'h0, !oe}, {31'h0, oe});
    if (oe && n >= 24)
      chk(bad == 0, ex[23] ? "R7 read response stream (R9 edge)" : "R8 echo with zero data (R9 edge)",
          {8'h0, got}, {8'h0, ex});
    chk(sdo_oe === 1'b0, "R5 sdo_oe low after frame", {31'h0, sdo_oe}, 32'h0);
    if (n >= 24) begin
      pend_m = next_pend(rw, sp, a);
      if (!rw) mem_m[a] = d;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    pend_m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(sdo_oe === 1'b0, "R1 sdo_oe after reset", {31'h0, sdo_oe}, 32'h0);
    core_chk(6'd0,  "R1 reg 0 after reset");
    core_chk(6'd2,  "R1 reg 2 after reset");
    core_chk(6'd63, "R1 reg 63 after reset");

    // R2 enable SDO, rising launch
    xfer(1'b0, 1'b1, 6'd2, 16'h0001, 24);
    core_chk(6'd2, "R2 cfg write");
    xfer(1'b0, 1'b0, 6'd5, 16'hBEEF, 24);   // R8 echo of previous write
    core_chk(6'd5, "R2 write reg 5");
    xfer(1'b1, 1'b1, 6'd5, 16'h0000, 24);
    xfer(1'b0, 1'b0, 6'd7, 16'h1357, 24);   // R7 readback of reg 5

    // R3 short frames ignored
    xfer(1'b0, 1'b0, 6'd5, 16'h1234, 23);
    core_chk(6'd5, "R3 short write ignored");
    xfer(1'b1, 1'b0, 6'd7, 16'h0000, 10);
    xfer(1'b0, 1'b1, 6'd8, 16'h0808, 24);   // response still from reg 7 write frame

    // R4 overlong frame
    xfer(1'b0, 1'b1, 6'd9, 16'hA5A5, 31);
    core_chk(6'd9, "R4 overlong write uses first bits");
    xfer(1'b1, 1'b0, 6'd9, 16'hFFFF, 29);
    xfer(1'b0, 1'b0, 6'd10, 16'h0F0F, 24);  // R7 readback of reg 9

    // R5 activity with cs_n high
    for (int i = 0; i < 40; i++) begin
      sclk = ~sclk; sdi = 1'($urandom);
      repeat (3) @(negedge clk);
      if (sdo_oe !== 1'b0) begin
        chk(1'b0, "R5 sdo_oe while deselected", {31'h0, sdo_oe}, 32'h0);
      end
    end
    sclk = 1'b0; sdi = 1'b0;
    repeat (GAP) @(negedge clk);
    core_chk(6'd10, "R5 reg unchanged by idle clocks");
    xfer(1'b0, 1'b0, 6'd11, 16'h1111, 24);  // R5 pending unchanged

    // R9 falling launch
    xfer(1'b0, 1'b0, 6'd2, 16'h0003, 24);
    xfer(1'b1, 1'b1, 6'd10, 16'h0000, 24);
    xfer(1'b1, 1'b0, 6'd63, 16'h0000, 24);
    xfer(1'b0, 1'b1, 6'd63, 16'hC3C3, 24);

    // R6 disabled driver
    xfer(1'b0, 1'b0, 6'd2, 16'h0002, 24);
    xfer(1'b1, 1'b0, 6'd63, 16'h0000, 24);
    xfer(1'b0, 1'b0, 6'd2, 16'h0001, 24);
    core_chk(6'd2, "R10 cfg readable on core port");

    // random traffic
    for (int k = 0; k < 110; k++) begin
      int sel;
      logic [5:0]  a;
      logic [15:0] d;
      sel = int'($urandom_range(0, 9));
      n = (sel == 0) ? int'($urandom_range(1, 23)) :
          (sel == 1) ? int'($urandom_range(25, 32)) : 24;
      a = 6'($urandom);
      d = 16'($urandom);
      if (a == 6'd2) d[0] = ($urandom_range(0, 3) != 0);
      xfer(1'($urandom), 1'($urandom), a, d, n);
    end
    for (int k = 0; k < 20; k++) core_chk(6'($urandom), "R10 core read port");
    summary();
  end
endmodule